// File: doc/BRIEF.md
# Variable-Size Memory Base Address Register

This block is a memory-space base address register for a PCI-style target. The register's window size is not fixed when the chip is built. A companion limit register chooses it at run time. Each base bit that the limit covers can be written. Every other base bit is frozen at zero. Standard sizing software can therefore write all ones to the base, read it back, and take the window size from the lowest set bit at or above bit 4. The smallest window is 16 bytes and the largest is 2 GB.

Both registers share one write port and one read port. Writes have per-byte lane enables, and `wr_sel` picks the register.

The three low attribute bits are constants. Bit 0 marks memory space. Bits 2:1 allow placement anywhere in 32-bit space. Bit 3 is a prefetch flag.

A combinational comparator raises `hit` when a 32-bit bus address falls inside the programmed window. The same module is instantiated three times, each with its own parameters:
- the primary-side inbound window,
- the secondary-side inbound window,
- the expansion ROM window.

Top module: `vbar_window`

## Requirements
- R1: After reset, base and limit both read 00000000h and `hit` is low.
- R2: Base read bits 2:0 are always 000 (bit 0 = memory space, bits 2:1 = 00 for anywhere in 32-bit space).
- R3: When the window is enabled (limit non-zero), base read bit 3 equals the `PREFETCH` parameter (1 in the default build).
- R4: A limit write is normalised to a contiguous mask. The bits are all ones from bit 31 down to the lowest set bit at or above `MIN_LSB` (default 4) of the lane-merged written value. The mask is zero if no such bit is set. Limit bits below `MIN_LSB` read 0.
- R5: Base bits [31:4] that the limit mask does not cover read 0 and are never changed by a base write.
- R6: After all ones are written to the base, the base reads back as mask | attribute bits. For example, limit FFFFFFF0h gives FFFFFFF8h (16 bytes), and limit 80000000h gives 80000008h (2 GB).
- R7: With a zero limit, the base reads 00000000h even after all ones are written.
- R8: A limit write clears, in the same clock edge, any stored base bits that the new mask no longer covers. Base bits that stay covered are kept.
- R9: Byte lane enable bit n gates data bits [8n+7:8n] for writes to either register. A write with no lanes enabled changes nothing.
- R10: `hit` is high in the same cycle when the limit is non-zero and (bus_addr & mask) == (base & mask).
- R11: `hit` is never high while the limit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = base, 1 = limit |
| wr_be | input | 4 | Per-byte lane write enables |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 = base, 1 = limit |
| rd_data | output | 32 | Combinational read data |
| bus_addr | input | 32 | Incoming bus address to decode |
| hit | output | 1 | Address falls inside the programmed window |

## Verification
Faults in this block show up at the read port at the first edge after the offending write. A stale base bit outside the mask, a non-contiguous limit or a lost lane update would all appear in the next read-back. A base bit that survives a shrinking limit write is visible one cycle after that write. A wrong window compare shows on `hit` in the same cycle the address is applied, so the bench compares both reads and `hit` every cycle against a behavioural model.

// File: rtl/vbar_pkg.sv
package vbar_pkg;

   localparam int unsigned VBAR_REG_W = 32;

   // register select for both the write and the read port
   typedef enum logic {
      SEL_BASE  = 1'b0,
      SEL_LIMIT = 1'b1
   } vbar_sel_e;

   // fixed attribute field positions in the base read word
   localparam int unsigned ATTR_MEM_BIT  = 0;
   localparam int unsigned ATTR_PF_BIT   = 3;
   localparam int unsigned ATTR_FIELD_W  = 4;

endpackage

// File: rtl/vbar_byte_merge.sv
module vbar_byte_merge #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]   old_val,
   input  logic [DATA_W-1:0]   new_val,
   input  logic [DATA_W/8-1:0] lane_en,
   output logic [DATA_W-1:0]   merged
);
   localparam int unsigned LANES = DATA_W / 8;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*8 +: 8] = lane_en[g] ? new_val[g*8 +: 8] : old_val[g*8 +: 8];
   end

endmodule

// File: rtl/vbar_limit_reg.sv
module vbar_limit_reg #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned MIN_LSB = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DATA_W/8-1:0] wr_be,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  mask_q,
   output logic [DATA_W-1:0]  mask_d
);
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] prefix;

   vbar_byte_merge #(.DATA_W(DATA_W)) u_merge (
      .old_val (mask_q),
      .new_val (wr_data),
      .lane_en (wr_be),
      .merged  (merged)
   );

   // running OR upward from the lowest writable bit: every bit at or above
   // the lowest set bit becomes one, giving a contiguous top-aligned mask
   always_comb begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < int'(DATA_W); i++) begin
         if (i >= int'(MIN_LSB)) acc = acc | merged[i];
         prefix[i] = acc;
      end
   end

   assign mask_d = wr_en ? prefix : mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   // R4: stored mask is always ones from the top down to one bit (or empty)
   a_r4_limit_contig: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(DATA_W'(~mask_q + 1'b1)))
      else $error("limit mask not contiguous");

   a_r4_limit_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[MIN_LSB-1:0] == '0)
      else $error("limit bits below minimum size set");

endmodule

// File: rtl/vbar_base_reg.sv
module vbar_base_reg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DATA_W/8-1:0] wr_be,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [DATA_W-1:0]  lim_q,
   input  logic [DATA_W-1:0]  lim_d,
   output logic [DATA_W-1:0]  base_q
);
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] base_d;

   vbar_byte_merge #(.DATA_W(DATA_W)) u_merge (
      .old_val (base_q),
      .new_val (wr_data),
      .lane_en (wr_be),
      .merged  (merged)
   );

   // next limit value gates the store, so a shrinking limit drops bits at once
   assign base_d = (wr_en ? merged : base_q) & lim_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q <= '0;
      else        base_q <= base_d;
   end

   // R5: no stored base bit lies outside the current limit mask
   a_r5_base_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (base_q & ~lim_q) == '0)
      else $error("base bit set outside limit mask");

endmodule

// File: rtl/vbar_hit_cmp.sv
module vbar_hit_cmp #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] base_q,
   input  logic [DATA_W-1:0] lim_q,
   output logic              hit
);
   logic window_on;
   logic match;

   assign window_on = |lim_q;
   assign match     = ((bus_addr ^ base_q) & lim_q) == '0;
   assign hit       = window_on & match;

endmodule

// File: rtl/vbar_window.sv
module vbar_window
   import vbar_pkg::*;
#(
   parameter int unsigned DATA_W   = VBAR_REG_W,
   parameter int unsigned MIN_LSB  = 4,
   parameter bit          PREFETCH = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [DATA_W/8-1:0] wr_be,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_sel,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [DATA_W-1:0]  bus_addr,
   output logic               hit
);
   localparam int unsigned LANES = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_width
      $error("vbar_window: DATA_W must be 32");
   end
   if (MIN_LSB < ATTR_FIELD_W || MIN_LSB > DATA_W - 1) begin : g_bad_lsb
      $error("vbar_window: MIN_LSB out of range");
   end
   if (LANES * 8 != DATA_W) begin : g_bad_lanes
      $error("vbar_window: DATA_W not a byte multiple");
   end

   logic [DATA_W-1:0] lim_q;
   logic [DATA_W-1:0] lim_d;
   logic [DATA_W-1:0] base_q;
   logic [DATA_W-1:0] attr;
   logic              lim_wr;
   logic              base_wr;

   assign lim_wr  = wr_en & (vbar_sel_e'(wr_sel) == SEL_LIMIT);
   assign base_wr = wr_en & (vbar_sel_e'(wr_sel) == SEL_BASE);

   // attribute field: memory space, 32-bit placement, optional prefetch flag
   if (PREFETCH) begin : g_pf
      assign attr = DATA_W'(1) << ATTR_PF_BIT;
   end else begin : g_no_pf
      assign attr = '0;
   end

   vbar_limit_reg #(.DATA_W(DATA_W), .MIN_LSB(MIN_LSB)) u_limit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lim_wr),
      .wr_be   (wr_be),
      .wr_data (wr_data),
      .mask_q  (lim_q),
      .mask_d  (lim_d)
   );

   vbar_base_reg #(.DATA_W(DATA_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (base_wr),
      .wr_be   (wr_be),
      .wr_data (wr_data),
      .lim_q   (lim_q),
      .lim_d   (lim_d),
      .base_q  (base_q)
   );

   vbar_hit_cmp #(.DATA_W(DATA_W)) u_hit (
      .bus_addr (bus_addr),
      .base_q   (base_q),
      .lim_q    (lim_q),
      .hit      (hit)
   );

   always_comb begin
      if (vbar_sel_e'(rd_sel) == SEL_LIMIT) rd_data = lim_q;
      else if (lim_q == '0)                 rd_data = '0;
      else                                  rd_data = base_q | attr;
   end

   a_r2_attr_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (vbar_sel_e'(rd_sel) == SEL_BASE) |-> (rd_data[2:ATTR_MEM_BIT] == 3'b000))
      else $error("base attribute bits 2:0 not zero");

   a_r3_prefetch_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ((vbar_sel_e'(rd_sel) == SEL_BASE) && (lim_q != '0)) |-> (rd_data[ATTR_PF_BIT] == PREFETCH))
      else $error("prefetch flag wrong");

   a_r9_no_lane_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_be == '0)) |=> ($stable(base_q) && $stable(lim_q)))
      else $error("write without lanes changed state");

   a_r11_no_hit_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (lim_q != '0))
      else $error("hit with disabled window");

endmodule

// File: tb/vbar_window_tb.sv
`timescale 1ns/1ps
module vbar_window_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [3:0]  wr_be = 4'h0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic [31:0] bus_addr = '0;
   logic        hit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string phase = "R1";

   // behavioural reference state
   logic [31:0] m_lim = '0;
   logic [31:0] m_base = '0;

   always #4 clk = ~clk;

   vbar_window u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_be    (wr_be),
      .wr_data  (wr_data),
      .rd_sel   (rd_sel),
      .rd_data  (rd_data),
      .bus_addr (bus_addr),
      .hit      (hit)
   );

   function automatic logic [31:0] lanes(input logic [31:0] old, input logic [31:0] nw,
                                         input logic [3:0] be);
      logic [31:0] r;
      r = old;
      for (int n = 0; n < 4; n++) if (be[n]) r[n*8 +: 8] = nw[n*8 +: 8];
      return r;
   endfunction

   function automatic logic [31:0] size_mask(input logic [31:0] v);
      int low;
      low = -1;
      for (int i = 31; i >= 4; i--) if (v[i]) low = i;
      if (low < 0) return 32'h0;
      return 32'hFFFF_FFFF << low;
   endfunction

   function automatic logic [31:0] exp_base();
      if (m_lim == 0) return 32'h0;
      return m_base | 32'h8;
   endfunction

   function automatic logic exp_hit();
      return (m_lim != 0) && ((bus_addr & m_lim) == m_base);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lim = '0;
         m_base = '0;
      end else if (wr_en) begin
         if (wr_sel) begin
            m_lim = size_mask(lanes(m_lim, wr_data, wr_be));
            m_base = m_base & m_lim;
         end else begin
            m_base = lanes(m_base, wr_data, wr_be) & m_lim;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic compare_all();
      rd_sel = 1'b0; #1;
      chk({phase, " base read vs model"}, rd_data, exp_base());
      rd_sel = 1'b1; #1;
      chk({phase, " limit read vs model"}, rd_data, m_lim);
      chk({phase, " hit vs model"}, {31'b0, hit}, {31'b0, exp_hit()});
   endtask

   task automatic do_write(input logic sel, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      compare_all();
   endtask

   task automatic dchk(input logic sel, input logic [31:0] exp, input string req);
      @(negedge clk);
      rd_sel = sel; #1;
      chk(req, rd_data, exp);
   endtask

   task automatic dhit(input logic [31:0] a, input logic exp, input string req);
      @(negedge clk);
      bus_addr = a; #1;
      chk(req, {31'b0, hit}, {31'b0, exp});
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #1_600_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1: reset state
      phase = "R1";
      dchk(1'b0, 32'h0, "R1 base after reset");
      dchk(1'b1, 32'h0, "R1 limit after reset");
      dhit(32'h0, 1'b0, "R1 hit after reset");
      @(negedge clk); rst_n = 1'b1;

      // R4 / R6 smallest window
      phase = "R4";
      do_write(1'b1, 4'hF, 32'hFFFF_FFFF);
      dchk(1'b1, 32'hFFFF_FFF0, "R4 limit normalised");
      phase = "R6";
      do_write(1'b0, 4'hF, 32'hFFFF_FFFF);
      dchk(1'b0, 32'hFFFF_FFF8, "R6 16-byte sizing");
      @(negedge clk); rd_sel = 1'b0; #1;
      chk("R2 attribute bits 2:0", {29'b0, rd_data[2:0]}, 32'h0);
      chk("R3 prefetch flag", {31'b0, rd_data[3]}, 32'h1);

      // R8 shrink to 2 GB clears immediately
      phase = "R8";
      do_write(1'b1, 4'hF, 32'h8000_0000);
      dchk(1'b0, 32'h8000_0008, "R8 base cleared by limit write");
      phase = "R6";
      do_write(1'b0, 4'hF, 32'hFFFF_FFFF);
      dchk(1'b0, 32'h8000_0008, "R6 2GB sizing");

      // R4 lowest set bit, R8 kept bits, R5 read-only bits
      phase = "R4";
      do_write(1'b1, 4'hF, 32'h00F0_1200);
      dchk(1'b1, 32'hFFFF_FE00, "R4 lowest set bit rule");
      dchk(1'b0, 32'h8000_0008, "R8 covered bit kept");
      phase = "R5";
      do_write(1'b0, 4'hF, 32'hFFFF_FFFF);
      dchk(1'b0, 32'hFFFF_FE08, "R5 read-only bits stay zero");

      // R7 / R11 disabled window
      phase = "R7";
      do_write(1'b1, 4'hF, 32'h0000_000F);
      dchk(1'b1, 32'h0, "R7 limit disabled");
      do_write(1'b0, 4'hF, 32'hFFFF_FFFF);
      dchk(1'b0, 32'h0, "R7 disabled base reads zero");
      dhit(32'h0, 1'b0, "R11 no hit at zero address");
      dhit(32'hFFFF_FFFF, 1'b0, "R11 no hit at top address");

      // R9 byte lanes
      phase = "R9";
      do_write(1'b1, 4'b1000, 32'hFFFF_FFFF);
      dchk(1'b1, 32'hFF00_0000, "R9 limit lane 3 only");
      do_write(1'b0, 4'b0100, 32'hFFFF_FFFF);
      dchk(1'b0, 32'h0000_0008, "R9 lane outside mask ignored");
      do_write(1'b0, 4'b1000, 32'h1234_5678);
      dchk(1'b0, 32'h1200_0008, "R9 base lane 3 written");
      do_write(1'b0, 4'b0000, 32'hFFFF_FFFF);
      dchk(1'b0, 32'h1200_0008, "R9 no lanes no change");
      do_write(1'b1, 4'b0001, 32'h0000_0010);
      dchk(1'b1, 32'hFFFF_FFF0, "R9 limit lane 0 merge");

      // R10 address compare
      phase = "R10";
      do_write(1'b1, 4'hF, 32'hFFF0_0000);
      do_write(1'b0, 4'hF, 32'hABC0_0000);
      dchk(1'b0, 32'hABC0_0008, "R10 base programmed");
      dhit(32'hABC1_2345, 1'b1, "R10 inside window");
      dhit(32'hABCF_FFFF, 1'b1, "R10 top of window");
      dhit(32'hABD0_0000, 1'b0, "R10 above window");
      dhit(32'hABBF_FFFF, 1'b0, "R10 below window");

      // random traffic against the model
      phase = "R10 R9 R5 random";
      for (int k = 0; k < 400; k++) begin
         logic sel;
         logic [31:0] d;
         sel = 1'($urandom);
         d = ($urandom % 3 == 0) ? (32'hFFFF_FFFF << ($urandom % 33)) : $urandom;
         @(negedge clk);
         bus_addr = ($urandom % 2 == 0) ? (m_base | ($urandom & ~m_lim)) : $urandom;
         do_write(sel, 4'($urandom), d);
      end

      done = 1'b1;
      finish_run();
   end

endmodule